// File: doc/BRIEF.md
# Comma-Aligned Serial-to-Parallel Receiver

This block sits behind a clock-recovery front end and runs on the recovered bit-rate clock. Each cycle it takes one serial bit and turns the stream into 10-bit parallel words, first-received bit in bit 0. A source selector picks either the external line or the local transmitter's own serial output (loopback). While loopback is active, the block also holds the external serial output at constant logic 1. When loopback is off, that output follows the transmitter.

When alignment is enabled, the block watches every 10-bit window for the seven-bit comma prefix. If the comma is at a new bit offset, the block moves the word boundary onto the comma. It then marks the comma word with a byte-sync flag and restarts the two half-rate byte clocks so that clock 1 is high for that word. When alignment is disabled, commas are plain data. The current word boundary and clock phase are kept as they are.

The parallel output is a stream with a valid strobe and no ready. A serial receiver cannot stall its line, so there is no back-pressure. Each word is presented for one `rx_valid_o` cycle and then held until the next word replaces it. A consumer must take it within one bit clock of the strobe, because a realignment can bring the next word as early as one cycle later.

Top module: `comma_deser`

## Requirements
- R1: A word is launched every 10 bit clocks. `rx_data_o[i]` holds the i-th of the last ten received bits, in receive order. `rx_valid_o` pulses high for exactly the launch cycle, and `rx_data_o` is held between launches.
- R2: A comma is a window whose first seven received bits are 0,0,1,1,1,1,1 (`rx_data_o[6:0]` = 7'b1111100). Bits 7 to 9 are ignored.
- R3: With `align_en_i` low, a comma changes nothing. There is no sync pulse, the word boundary stays where it is, and the byte clocks keep alternating.
- R4: `byte_clk0_o` is always the inverse of `byte_clk1_o`. Each normal launch toggles them, so each clock runs at half the word rate and successive words rise alternately on clock 1 and clock 0.
- R5: The comma word is presented with `byte_clk1_o` high. It makes a rising edge of clock 1 whenever the previous word was on clock 0.
- R6: With alignment enabled, a comma at a new offset is launched in the cycle its tenth bit arrives. The partial word is dropped, and later words follow every 10 bits from there.
- R7: A comma that lands on the current boundary only raises byte-sync. The word spacing is unchanged.
- R8: `rx_sync_o` is high only together with `rx_valid_o` on the word that carries the comma.
- R9: With `loopback_i` high, words are built from `tx_ser_i` and `line_rx_i` is ignored. With `loopback_i` low, words are built from `line_rx_i`.
- R10: `line_tx_o` is 1 while `loopback_i` is high, and equals `tx_ser_i` otherwise.
- R11: Synchronous reset gives `rx_data_o`=0, `rx_valid_o`=0, `rx_sync_o`=0, `byte_clk0_o`=1, `byte_clk1_o`=0, and restarts word counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| line_rx_i | input | 1 | External serial line input |
| tx_ser_i | input | 1 | Local transmitter serial bit |
| loopback_i | input | 1 | 1 selects the transmitter as the receive source |
| align_en_i | input | 1 | 1 enables comma alignment |
| line_tx_o | output | 1 | External serial output (forced 1 in loopback) |
| rx_data_o | output | 10 | Parallel word, bit 0 received first |
| rx_valid_o | output | 1 | One-cycle strobe per launched word |
| rx_sync_o | output | 1 | Marks the comma word |
| byte_clk0_o | output | 1 | Half-rate byte clock, phase 0 |
| byte_clk1_o | output | 1 | Half-rate byte clock, phase 1 |

## Verification
The framing path is driven with comma-free words, which confirms bit ordering and the ten-bit cadence. The same stream is then sent with a comma split across a word boundary, once with alignment off and once with it on. This separates correct ignoring from an early launch at the new offset. An idle-style stream with commas already on the boundary shows that aligned commas only mark the word. A comma sent after alignment is switched off shows that the acquired boundary survives. In loopback, the line carries commas while the transmitter carries data, so any leak from the wrong source shows up as a sync pulse or a wrong word.

// File: rtl/comma_deser_pkg.sv
package comma_deser_pkg;
  localparam int unsigned WORD_W_DEF  = 10;
  localparam int unsigned COMMA_W_DEF = 7;
  // bit i is the i-th received bit: 0,0,1,1,1,1,1
  localparam logic [6:0]  COMMA_DEF   = 7'b1111100;

  typedef enum logic [1:0] {
    LAUNCH_NONE,
    LAUNCH_BOUNDARY,
    LAUNCH_REALIGN
  } launch_e;
endpackage

// File: rtl/deser_src_sel.sv
module deser_src_sel (
  input  logic line_rx_i,
  input  logic tx_ser_i,
  input  logic loopback_i,
  output logic bit_o,
  output logic line_tx_o
);
  always_comb begin
    bit_o     = loopback_i ? tx_ser_i : line_rx_i;
    line_tx_o = loopback_i ? 1'b1 : tx_ser_i;
  end
endmodule

// File: rtl/deser_shift.sv
module deser_shift #(
  parameter int unsigned WORD_W  = comma_deser_pkg::WORD_W_DEF,
  parameter int unsigned COMMA_W = comma_deser_pkg::COMMA_W_DEF,
  parameter logic [COMMA_W-1:0] COMMA = comma_deser_pkg::COMMA_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_i,
  output logic [WORD_W-1:0] win_o,
  output logic              comma_o
);
  logic [WORD_W-1:0] sh_q;

  // newest bit enters at the top; oldest sits in bit 0
  always_comb begin
    win_o   = {bit_i, sh_q[WORD_W-1:1]};
    comma_o = (win_o[COMMA_W-1:0] == COMMA);
  end

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= win_o;
  end
endmodule

// File: rtl/deser_frame.sv
module deser_frame #(
  parameter int unsigned WORD_W = comma_deser_pkg::WORD_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] win_i,
  input  logic              comma_i,
  input  logic              align_en_i,
  output logic [WORD_W-1:0] data_o,
  output logic              valid_o,
  output logic              sync_o,
  output logic              bclk0_o,
  output logic              bclk1_o
);
  import comma_deser_pkg::*;

  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             ph_q;
  logic             hit;
  logic             at_edge;
  launch_e          launch;

  always_comb begin
    hit     = align_en_i && comma_i;
    at_edge = (cnt_q == LAST);
    if (hit && !at_edge) launch = LAUNCH_REALIGN;
    else if (at_edge)    launch = LAUNCH_BOUNDARY;
    else                 launch = LAUNCH_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      ph_q    <= 1'b0;
      data_o  <= '0;
      valid_o <= 1'b0;
      sync_o  <= 1'b0;
    end else begin
      valid_o <= (launch != LAUNCH_NONE);
      sync_o  <= hit;
      if (launch != LAUNCH_NONE) begin
        data_o <= win_i;
        cnt_q  <= '0;
        ph_q   <= hit ? 1'b1 : ~ph_q;
      end else begin
        cnt_q  <= cnt_q + CNT_W'(1);
      end
    end
  end

  always_comb begin
    bclk1_o = ph_q;
    bclk0_o = ~ph_q;
  end
endmodule

// File: rtl/comma_deser.sv
module comma_deser #(
  parameter int unsigned WORD_W  = comma_deser_pkg::WORD_W_DEF,
  parameter int unsigned COMMA_W = comma_deser_pkg::COMMA_W_DEF,
  parameter logic [COMMA_W-1:0] COMMA = comma_deser_pkg::COMMA_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_rx_i,
  input  logic              tx_ser_i,
  input  logic              loopback_i,
  input  logic              align_en_i,
  output logic              line_tx_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              rx_sync_o,
  output logic              byte_clk0_o,
  output logic              byte_clk1_o
);
  logic              rx_bit;
  logic [WORD_W-1:0] win;
  logic              comma;

  deser_src_sel u_sel (
    .line_rx_i (line_rx_i),
    .tx_ser_i  (tx_ser_i),
    .loopback_i(loopback_i),
    .bit_o     (rx_bit),
    .line_tx_o (line_tx_o)
  );

  deser_shift #(.WORD_W(WORD_W), .COMMA_W(COMMA_W), .COMMA(COMMA)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .bit_i  (rx_bit),
    .win_o  (win),
    .comma_o(comma)
  );

  deser_frame #(.WORD_W(WORD_W)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .win_i     (win),
    .comma_i   (comma),
    .align_en_i(align_en_i),
    .data_o    (rx_data_o),
    .valid_o   (rx_valid_o),
    .sync_o    (rx_sync_o),
    .bclk0_o   (byte_clk0_o),
    .bclk1_o   (byte_clk1_o)
  );
endmodule

// File: rtl/comma_deser_chk.sv
module comma_deser_chk #(
  parameter int unsigned WORD_W  = 10,
  parameter int unsigned COMMA_W = 7,
  parameter logic [COMMA_W-1:0] COMMA = 7'b1111100
) (
  input logic              clk,
  input logic              rst,
  input logic              loopback_i,
  input logic              align_en_i,
  input logic              line_tx_o,
  input logic [WORD_W-1:0] rx_data_o,
  input logic              rx_valid_o,
  input logic              rx_sync_o,
  input logic              byte_clk0_o,
  input logic              byte_clk1_o
);
  logic [7:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst)             gap_q <= '0;
    else if (rx_valid_o) gap_q <= 8'd1;
    else if (gap_q != 8'hFF) gap_q <= gap_q + 8'd1;
  end

  p_spacing_r1: assert property (@(posedge clk) disable iff (rst)
    (rx_valid_o && !rx_sync_o) |-> gap_q == 8'(WORD_W));

  p_data_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !rx_valid_o |-> $stable(rx_data_o));

  p_clk_opposite_r4: assert property (@(posedge clk) disable iff (rst)
    byte_clk0_o != byte_clk1_o);

  p_clk_toggle_r4: assert property (@(posedge clk) disable iff (rst)
    (rx_valid_o && !rx_sync_o) |-> byte_clk1_o != $past(byte_clk1_o));

  p_clk_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !rx_valid_o |-> $stable(byte_clk1_o));

  p_sync_en_r3: assert property (@(posedge clk) disable iff (rst)
    rx_sync_o |-> $past(align_en_i));

  p_sync_clk1_r5: assert property (@(posedge clk) disable iff (rst)
    rx_sync_o |-> byte_clk1_o);

  p_sync_word_r8: assert property (@(posedge clk) disable iff (rst)
    rx_sync_o |-> (rx_valid_o && rx_data_o[COMMA_W-1:0] == COMMA));

  p_line_hold_r10: assert property (@(posedge clk) disable iff (rst)
    loopback_i |-> line_tx_o);
endmodule

bind comma_deser comma_deser_chk #(
  .WORD_W(WORD_W), .COMMA_W(COMMA_W), .COMMA(COMMA)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .loopback_i (loopback_i),
  .align_en_i (align_en_i),
  .line_tx_o  (line_tx_o),
  .rx_data_o  (rx_data_o),
  .rx_valid_o (rx_valid_o),
  .rx_sync_o  (rx_sync_o),
  .byte_clk0_o(byte_clk0_o),
  .byte_clk1_o(byte_clk1_o)
);

// File: tb/tb_comma_deser.sv
`timescale 1ns/1ps
module tb_comma_deser;
  localparam logic [9:0] W_P = 10'h2AA;
  localparam logic [9:0] W_A = 10'h22A;
  localparam logic [9:0] W_B = 10'h14F;
  localparam logic [9:0] W_C = 10'h155;
  localparam logic [9:0] W_K = 10'h17C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_rx_i = 1'b0, tx_ser_i = 1'b0, loopback_i = 1'b0, align_en_i = 1'b0;
  logic line_tx_o, rx_valid_o, rx_sync_o, byte_clk0_o, byte_clk1_o;
  logic [9:0] rx_data_o;

  always #2.5 clk = ~clk;

  comma_deser dut (
    .clk(clk), .rst(rst), .line_rx_i(line_rx_i), .tx_ser_i(tx_ser_i),
    .loopback_i(loopback_i), .align_en_i(align_en_i), .line_tx_o(line_tx_o),
    .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .rx_sync_o(rx_sync_o),
    .byte_clk0_o(byte_clk0_o), .byte_clk1_o(byte_clk1_o)
  );

  int checks = 0, errors = 0;
  logic sent [0:1023];
  int bitcount = 0;
  logic [9:0] cap_data [0:63];
  logic cap_sync [0:63];
  logic cap_b1 [0:63];
  logic cap_b0 [0:63];
  int cap_end [0:63];
  int ncap = 0;

  always @(posedge clk) begin
    #1;
    if (!rst && rx_valid_o && ncap < 64) begin
      cap_data[ncap] = rx_data_o;
      cap_sync[ncap] = rx_sync_o;
      cap_b1[ncap]   = byte_clk1_o;
      cap_b0[ncap]   = byte_clk0_o;
      cap_end[ncap]  = bitcount;
      ncap = ncap + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [9:0] slice(input int e);
    logic [9:0] s;
    for (int i = 0; i < 10; i++) s[i] = sent[e - 10 + i];
    return s;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    bitcount = 0;
    ncap = 0;
  endtask

  task automatic send_bit(input logic lb, input logic tb, input logic en);
    @(negedge clk);
    rst = 1'b0;
    align_en_i = en;
    line_rx_i = lb;
    tx_ser_i = tb;
    sent[bitcount] = loopback_i ? tb : lb;
    bitcount++;
  endtask

  task automatic send_word(input logic [9:0] w, input logic en);
    for (int i = 0; i < 10; i++) send_bit(w[i], 1'b0, en);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic check_cap(input int k, input int e, input logic s,
                           input logic b1, input string req);
    if (k >= ncap) begin
      chk(1'b0, req, "word missing", ncap, k + 1);
    end else begin
      chk(cap_end[k] == e, req, "word end", cap_end[k], e);
      chk(cap_data[k] == slice(e), req, "word data", cap_data[k], slice(e));
      chk(cap_sync[k] == s, req, "sync", cap_sync[k], s);
      chk(cap_b1[k] == b1, req, "byte clk1", cap_b1[k], b1);
      chk(cap_b0[k] == !b1, req, "byte clk0", cap_b0[k], !b1);
    end
  endtask

  // R11: reset values
  task automatic t_reset();
    do_reset();
    chk(rx_data_o == 10'h0, "R11", "data", rx_data_o, 0);
    chk(rx_valid_o == 1'b0, "R11", "valid", rx_valid_o, 0);
    chk(rx_sync_o == 1'b0, "R11", "sync", rx_sync_o, 0);
    chk(byte_clk0_o == 1'b1, "R11", "clk0", byte_clk0_o, 1);
    chk(byte_clk1_o == 1'b0, "R11", "clk1", byte_clk1_o, 0);
  endtask

  // R1, R4: plain framing, clock alternation
  task automatic t_plain();
    do_reset();
    send_word(10'h2AA, 1'b1); send_word(10'h155, 1'b1); send_word(10'h0F0, 1'b1);
    settle();
    chk(ncap == 3, "R1", "word count", ncap, 3);
    check_cap(0, 10, 1'b0, 1'b1, "R1");
    check_cap(1, 20, 1'b0, 1'b0, "R4");
    check_cap(2, 30, 1'b0, 1'b1, "R4");
    chk(cap_data[0] == 10'h2AA, "R1", "first word", cap_data[0], 10'h2AA);
  endtask

  // R3: comma across boundary ignored with alignment off
  task automatic t_disabled();
    do_reset();
    send_word(W_P, 1'b0); send_word(W_A, 1'b0); send_word(W_B, 1'b0);
    send_word(W_C, 1'b0); send_word(W_P, 1'b0);
    settle();
    chk(ncap == 5, "R3", "word count", ncap, 5);
    check_cap(2, 30, 1'b0, 1'b1, "R3");
    check_cap(4, 50, 1'b0, 1'b1, "R3");
  endtask

  // R2, R5, R6, R8: comma at new offset
  task automatic t_realign();
    do_reset();
    send_word(W_P, 1'b1); send_word(W_A, 1'b1); send_word(W_B, 1'b1);
    send_word(W_C, 1'b1); send_word(W_P, 1'b1);
    settle();
    chk(ncap == 5, "R6", "word count", ncap, 5);
    check_cap(1, 20, 1'b0, 1'b0, "R6");
    check_cap(2, 27, 1'b1, 1'b1, "R5");
    chk(cap_data[2] == 10'h27C, "R2", "comma word", cap_data[2], 10'h27C);
    check_cap(3, 37, 1'b0, 1'b0, "R8");
    check_cap(4, 47, 1'b0, 1'b1, "R6");
  endtask

  // R7: comma on current boundary
  task automatic t_aligned();
    do_reset();
    send_word(W_K, 1'b1); send_word(W_P, 1'b1); send_word(W_K, 1'b1); send_word(W_C, 1'b1);
    settle();
    chk(ncap == 4, "R7", "word count", ncap, 4);
    check_cap(0, 10, 1'b1, 1'b1, "R7");
    check_cap(1, 20, 1'b0, 1'b0, "R8");
    check_cap(2, 30, 1'b1, 1'b1, "R5");
    check_cap(3, 40, 1'b0, 1'b0, "R7");
  endtask

  // R3: acquired boundary kept when alignment is switched off
  task automatic t_keep();
    do_reset();
    send_word(W_P, 1'b1); send_word(W_A, 1'b1); send_word(W_B, 1'b1); send_word(W_C, 1'b1);
    send_word(W_K, 1'b0); send_word(W_P, 1'b0); send_word(W_P, 1'b0);
    settle();
    chk(ncap == 7, "R3", "word count", ncap, 7);
    check_cap(2, 27, 1'b1, 1'b1, "R6");
    check_cap(4, 47, 1'b0, 1'b1, "R3");
    check_cap(5, 57, 1'b0, 1'b0, "R3");
    check_cap(6, 67, 1'b0, 1'b1, "R3");
  endtask

  // R9, R10: loopback source and line output
  task automatic t_loop();
    logic [9:0] tw [0:2];
    tw[0] = 10'h2AA; tw[1] = 10'h155; tw[2] = 10'h2AA;
    do_reset();
    loopback_i = 1'b1;
    for (int w = 0; w < 3; w++)
      for (int i = 0; i < 10; i++) send_bit(W_K[i], tw[w][i], 1'b1);
    settle();
    chk(ncap == 3, "R9", "word count", ncap, 3);
    check_cap(0, 10, 1'b0, 1'b1, "R9");
    check_cap(1, 20, 1'b0, 1'b0, "R9");
    chk(cap_data[1] == 10'h155, "R9", "looped word", cap_data[1], 10'h155);
    @(negedge clk); tx_ser_i = 1'b0; #1;
    chk(line_tx_o == 1'b1, "R10", "held line in loopback", line_tx_o, 1);
    @(negedge clk); loopback_i = 1'b0; tx_ser_i = 1'b0; #1;
    chk(line_tx_o == 1'b0, "R10", "line follows tx 0", line_tx_o, 0);
    @(negedge clk); tx_ser_i = 1'b1; #1;
    chk(line_tx_o == 1'b1, "R10", "line follows tx 1", line_tx_o, 1);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_plain();
    t_disabled();
    t_realign();
    t_aligned();
    t_reset();
    t_keep();
    t_loop();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule